// File: doc/BRIEF.md
# Inter-Processor and Timer Interrupt Controller

This block holds, for up to four processors, a pending inter-processor interrupt (IPI) bit and a pending interval-timer bit, and drives one IPI line and one timer line per processor. Software reaches it through a single 32-bit control word. Within one write, separate nibble fields request IPIs, withdraw IPIs and acknowledge timer interrupts, each field a processor mask. A read returns both pending vectors and the number of the processor that is reading.

An external tick pulse, produced by a timer outside this block, raises the timer interrupt on every present processor. An IPI request aimed at a processor that already has one pending is dropped rather than applied, and so is a withdrawal aimed at a processor with nothing pending. Each of these dropped events sets a sticky flag. For each processor the block also reports the highest active level among device, timer and IPI interrupts. The device request is an input here, since device routing happens elsewhere.

Top module: `ipi_tmr_intc`

## Requirements
- R1: After reset every pending IPI and timer bit is 0, all lines are low, both warning flags are 0 and every level code is 0.
- R2: A write with bit 28 clear takes its fields from the data word: bits [15:12] request an IPI, bits [11:8] withdraw an IPI, and bits [7:4] acknowledge a timer interrupt, bit n in each field addressing processor n. The lines reflect the write from the next clock edge.
- R3: An IPI request to a processor with no IPI pending sets its bit. A request to a processor whose IPI is already pending leaves the bit set and sets the sticky flag `warn_ipi_dup`.
- R4: An IPI withdrawal clears a pending bit. A withdrawal aimed at a processor with no IPI pending changes nothing and sets the sticky flag `warn_ipi_idle`.
- R5: Within one write, withdrawal is applied before request. Requesting and withdrawing a pending IPI together leaves it pending without `warn_ipi_dup`. Doing both to an idle processor sets the bit and raises `warn_ipi_idle` only.
- R6: A timer acknowledge clears only those processors that are both in the mask and pending. Acknowledging an idle processor has no effect.
- R7: A `tick` pulse sets the timer bit of every present processor. When a tick and an acknowledge arrive in the same cycle, the tick wins.
- R8: A write with bit 28 set is accepted and changes nothing: no pending bit and no flag.
- R9: Processors numbered NUM_CPU and above are absent. Their mask bits and ticks are ignored, their lines and level code stay 0, and they never raise a flag.
- R10: `rd_data` is combinational. It carries the IPI vector in [11:8], the timer vector in [7:4] and `rd_cpu` in [1:0], with all other bits 0.
- R11: `cpu_lvl[2n+1:2n]` is 3 when processor n has an IPI pending, else 2 when its timer bit is pending, else 1 when its device request is high, else 0.
- R12: Both warning flags stay set once raised, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Control word written |
| rd_cpu | input | 2 | Number of the processor performing the read |
| rd_data | output | 32 | Read view of the pending state |
| tick | input | 1 | Interval-timer pulse |
| dev_irq | input | 4 | Device interrupt request per processor |
| ipi_irq | output | 4 | IPI line per processor |
| tmr_irq | output | 4 | Timer line per processor |
| cpu_lvl | output | 8 | Highest active level per processor, 2 bits each |
| warn_ipi_dup | output | 1 | Sticky: IPI request hit an already pending processor |
| warn_ipi_idle | output | 1 | Sticky: IPI withdrawal hit an idle processor |

## Verification
The bench builds the block with NUM_CPU = 3. The top slot of every mask, and of the tick broadcast, therefore addresses an absent processor. Writes of all-ones fields, ticks and device requests then show that slot 3 stays silent while slots 0 to 2 respond. With the default of 4, every slot would be present and the masking path would never be exercised.

// File: rtl/ipi_tmr_pkg.sv
package ipi_tmr_pkg;
  localparam int SLOTS    = 4;
  localparam int REQ_LSB  = 12;
  localparam int CLR_LSB  = 8;
  localparam int ACK_LSB  = 4;
  localparam int NOOP_BIT = 28;
  localparam int LVL_W    = 2;

  typedef logic [SLOTS-1:0] cpu_vec_t;

  typedef enum logic [LVL_W-1:0] {
    LVL_NONE = 2'd0,
    LVL_DEV  = 2'd1,
    LVL_TMR  = 2'd2,
    LVL_IPI  = 2'd3
  } lvl_e;

  typedef struct packed {
    cpu_vec_t req;
    cpu_vec_t clr;
    cpu_vec_t ack;
  } wr_cmd_t;
endpackage

// File: rtl/ipi_tmr_decode.sv
module ipi_tmr_decode
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output wr_cmd_t     cmd
);
  localparam cpu_vec_t PRESENT = cpu_vec_t'((1 << NUM_CPU) - 1);

  logic live;

  always_comb begin
    live    = wr_en && !wr_data[NOOP_BIT];
    cmd     = '0;
    if (live) begin
      cmd.req = wr_data[REQ_LSB +: SLOTS] & PRESENT;
      cmd.clr = wr_data[CLR_LSB +: SLOTS] & PRESENT;
      cmd.ack = wr_data[ACK_LSB +: SLOTS] & PRESENT;
    end
  end

  always_comb begin
    // R8: a write with the no-op bit set must produce no command at all
    a_r8_noop_silent: assert (!(wr_en && wr_data[NOOP_BIT]) || cmd == '0);
  end
endmodule

// File: rtl/ipi_tmr_ipi_bank.sv
module ipi_tmr_ipi_bank
  import ipi_tmr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  cpu_vec_t req,
  input  cpu_vec_t clr,
  output cpu_vec_t ipi_q,
  output logic     warn_dup_q,
  output logic     warn_idle_q
);
  cpu_vec_t after_clr;
  cpu_vec_t ipi_d;
  logic     ev_dup;
  logic     ev_idle;
  logic     ipi_en;
  logic     dup_d;
  logic     idle_d;

  always_comb begin
    after_clr = ipi_q & ~clr;
    ev_idle   = |(clr & ~ipi_q);
    ev_dup    = |(req & after_clr);
    ipi_d     = after_clr | req;
    ipi_en    = |(req | clr);
    dup_d     = warn_dup_q | ev_dup;
    idle_d    = warn_idle_q | ev_idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ipi_q       <= '0;
      warn_dup_q  <= 1'b0;
      warn_idle_q <= 1'b0;
    end else begin
      if (ipi_en) ipi_q <= ipi_d;
      if (ev_dup) warn_dup_q <= dup_d;
      if (ev_idle) warn_idle_q <= idle_d;
    end
  end

  // R3: requested processors are pending after the edge
  a_r3_req_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (req != '0) |=> ((ipi_q & $past(req)) == $past(req)));
  // R4: withdrawn processors not re-requested are clear after the edge
  a_r4_clr_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~req) != '0) |=> ((ipi_q & $past(clr & ~req)) == '0));
  // R4: withdrawing an idle processor raises the idle flag
  a_r4_idle_flag: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr & ~ipi_q) != '0) |=> warn_idle_q);
  // R12: both flags are sticky
  a_r12_dup_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    warn_dup_q |=> warn_dup_q);
  a_r12_idle_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    warn_idle_q |=> warn_idle_q);
endmodule

// File: rtl/ipi_tmr_tick_bank.sv
module ipi_tmr_tick_bank
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  cpu_vec_t ack,
  output cpu_vec_t tmr_q
);
  localparam cpu_vec_t PRESENT = cpu_vec_t'((1 << NUM_CPU) - 1);

  cpu_vec_t tmr_d;
  logic     tmr_en;

  always_comb begin
    tmr_d  = tmr_q & ~ack;
    if (tick) tmr_d = tmr_d | PRESENT;
    tmr_en = tick || (ack != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tmr_q <= '0;
    else if (tmr_en) tmr_q <= tmr_d;
  end

  // R7: after a tick every present processor has its timer bit
  a_r7_tick_posts: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> ((tmr_q & PRESENT) == PRESENT));
  // R6: an acknowledge without a tick clears the acknowledged bits
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && ack != '0) |=> ((tmr_q & $past(ack)) == '0));
endmodule

// File: rtl/ipi_tmr_level_enc.sv
module ipi_tmr_level_enc
  import ipi_tmr_pkg::*;
(
  input  cpu_vec_t                 ipi,
  input  cpu_vec_t                 tmr,
  input  cpu_vec_t                 dev,
  output logic [SLOTS*LVL_W-1:0]   lvl
);
  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    lvl_e code;
    always_comb begin
      if (ipi[g])      code = LVL_IPI;
      else if (tmr[g]) code = LVL_TMR;
      else if (dev[g]) code = LVL_DEV;
      else             code = LVL_NONE;
    end
    assign lvl[g*LVL_W +: LVL_W] = code;

    always_comb begin
      // R11: a pending IPI dominates every lower source
      a_r11_ipi_top: assert (!ipi[g] || lvl[g*LVL_W +: LVL_W] == 2'd3);
    end
  end
endmodule

// File: rtl/ipi_tmr_intc.sv
module ipi_tmr_intc
  import ipi_tmr_pkg::*;
#(
  parameter int NUM_CPU = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic [1:0]  rd_cpu,
  output logic [31:0] rd_data,
  input  logic        tick,
  input  logic [3:0]  dev_irq,
  output logic [3:0]  ipi_irq,
  output logic [3:0]  tmr_irq,
  output logic [7:0]  cpu_lvl,
  output logic        warn_ipi_dup,
  output logic        warn_ipi_idle
);
  localparam cpu_vec_t PRESENT = cpu_vec_t'((1 << NUM_CPU) - 1);

  wr_cmd_t  cmd;
  cpu_vec_t ipi_q;
  cpu_vec_t tmr_q;
  cpu_vec_t dev_live;

  ipi_tmr_decode #(.NUM_CPU(NUM_CPU)) u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  ipi_tmr_ipi_bank u_ipi (
    .clk         (clk),
    .rst_n       (rst_n),
    .req         (cmd.req),
    .clr         (cmd.clr),
    .ipi_q       (ipi_q),
    .warn_dup_q  (warn_ipi_dup),
    .warn_idle_q (warn_ipi_idle)
  );

  ipi_tmr_tick_bank #(.NUM_CPU(NUM_CPU)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick),
    .ack   (cmd.ack),
    .tmr_q (tmr_q)
  );

  assign dev_live = dev_irq & PRESENT;

  ipi_tmr_level_enc u_lvl (
    .ipi (ipi_q),
    .tmr (tmr_q),
    .dev (dev_live),
    .lvl (cpu_lvl)
  );

  always_comb begin
    rd_data = '0;
    rd_data[CLR_LSB +: SLOTS] = ipi_q;
    rd_data[ACK_LSB +: SLOTS] = tmr_q;
    rd_data[1:0]              = rd_cpu;
  end

  assign ipi_irq = ipi_q;
  assign tmr_irq = tmr_q;

  // R9: absent processors never show a pending line
  a_r9_absent_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((ipi_irq | tmr_irq) & ~PRESENT) == '0);
  // R8: a no-op write leaves the IPI lines unchanged
  a_r8_noop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[NOOP_BIT]) |=> $stable(ipi_irq));
endmodule

// File: tb/ipi_tmr_intc_tb_top.sv
module ipi_tmr_intc_tb_top;
  localparam int NCPU = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_cpu = '0;
  logic        tick = 1'b0;
  logic [3:0]  dev_irq = '0;
  logic [31:0] rd_data;
  logic [3:0]  ipi_irq, tmr_irq;
  logic [7:0]  cpu_lvl;
  logic        warn_ipi_dup, warn_ipi_idle;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  ipi_tmr_intc #(.NUM_CPU(NCPU)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_cpu(rd_cpu), .rd_data(rd_data), .tick(tick), .dev_irq(dev_irq),
    .ipi_irq(ipi_irq), .tmr_irq(tmr_irq), .cpu_lvl(cpu_lvl),
    .warn_ipi_dup(warn_ipi_dup), .warn_ipi_idle(warn_ipi_idle)
  );

  // Behavioural reference model
  int m_ipi [4];
  int m_tmr [4];
  int m_dup, m_idle;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 4; c++) begin m_ipi[c] = 0; m_tmr[c] = 0; end
      m_dup = 0; m_idle = 0;
    end else begin
      if (wr_en && !wr_data[28]) begin
        for (int c = 0; c < NCPU; c++) begin
          if (wr_data[8+c]) begin
            if (m_ipi[c] != 0) m_ipi[c] = 0; else m_idle = 1;
          end
          if (wr_data[12+c]) begin
            if (m_ipi[c] != 0) m_dup = 1; else m_ipi[c] = 1;
          end
          if (wr_data[4+c]) m_tmr[c] = 0;
        end
      end
      if (tick) for (int c = 0; c < NCPU; c++) m_tmr[c] = 1;
    end
  end

  function automatic logic [3:0] vec(input int a [4]);
    logic [3:0] v;
    for (int c = 0; c < 4; c++) v[c] = (a[c] != 0);
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Compare on every falling edge, before new stimulus is driven
  always @(negedge clk) begin
    logic [7:0] el;
    logic [31:0] er;
    cycles++;
    if (rst_n) begin
      for (int c = 0; c < 4; c++) begin
        if (m_ipi[c] != 0)                el[2*c +: 2] = 2'd3;
        else if (m_tmr[c] != 0)           el[2*c +: 2] = 2'd2;
        else if (c < NCPU && dev_irq[c])  el[2*c +: 2] = 2'd1;
        else                              el[2*c +: 2] = 2'd0;
      end
      er = {20'd0, vec(m_ipi), vec(m_tmr), 2'b00, rd_cpu};
      chk("R3/R4/R5/R9 ipi_irq", {28'd0, ipi_irq}, {28'd0, vec(m_ipi)});
      chk("R6/R7/R9 tmr_irq", {28'd0, tmr_irq}, {28'd0, vec(m_tmr)});
      chk("R3/R12 warn_ipi_dup", {31'd0, warn_ipi_dup}, m_dup);
      chk("R4/R12 warn_ipi_idle", {31'd0, warn_ipi_idle}, m_idle);
      chk("R10 rd_data", rd_data, er);
      chk("R11 cpu_lvl", {24'd0, cpu_lvl}, {24'd0, el});
    end
  end

  task automatic wr(input logic [31:0] d, input logic t);
    @(negedge clk); #0.5;
    wr_en = 1'b1; wr_data = d; tick = t;
    @(negedge clk); #0.5;
    wr_en = 1'b0; wr_data = '0; tick = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #80000;
    fails++;
    $display("FAIL watchdog: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    #9 rst_n = 1'b1;
    @(negedge clk); #0.5;
    // R1: state right after reset
    chk("R1 reset ipi", {28'd0, ipi_irq}, 32'd0);
    chk("R1 reset lvl", {24'd0, cpu_lvl}, 32'd0);
    // R2/R3: request IPI on processors 0 and 1
    wr(32'h0000_3000, 1'b0);
    // R3: duplicate request to processor 0
    wr(32'h0000_1000, 1'b0);
    // R4: withdraw idle processor 2, then withdraw processor 1
    wr(32'h0000_0400, 1'b0);
    wr(32'h0000_0200, 1'b0);
    // R5: withdraw+request processor 0 (pending) and processor 2 (idle)
    wr(32'h0000_5500, 1'b0);
    // R7: tick posts timers
    wr(32'h0000_0000, 1'b1);
    // R6: acknowledge processors 1 and 2
    wr(32'h0000_0060, 1'b0);
    // R6: acknowledge idle processor 1 is ignored
    wr(32'h0000_0020, 1'b0);
    // R7: tick together with acknowledge, tick wins
    wr(32'h0000_0070, 1'b1);
    // R8: no-op write with all fields set
    wr(32'h1000_FFF0, 1'b0);
    // R9: masks aimed at absent processor 3 and device request on it
    dev_irq = 4'b1000;
    wr(32'h0000_8880, 1'b0);
    // R11: device requests while lines clear
    wr(32'h0000_0570, 1'b0);
    dev_irq = 4'b1111;
    idle(2);
    // R10: read view from every processor number
    for (int k = 0; k < 4; k++) begin rd_cpu = k[1:0]; idle(1); end
    // R1/R12: reset clears sticky flags
    rst_n = 1'b0; #3 rst_n = 1'b1;
    idle(2);
    chk("R12 flags cleared by reset", {30'd0, warn_ipi_dup, warn_ipi_idle}, 32'd0);
    // Mixed traffic from a fixed LFSR
    lf = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk); #0.5;
      wr_en   = lf[0];
      wr_data = {3'd0, lf[1] & lf[2] & lf[3], 12'd0, lf[15:4], 4'd0};
      tick    = lf[2] & lf[5];
      dev_irq = lf[11:8];
      rd_cpu  = lf[7:6];
    end
    @(negedge clk); #0.5;
    wr_en = 1'b0; tick = 1'b0;
    idle(3);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule